// File: doc/BRIEF.md
# SMBus host register interface

This block is the byte-wide register file that software uses to run an SMBus host controller. Software programs a target address, a command byte, two data bytes and a protocol code. It then sets the start bit in the control register. The block checks the request and launches it to a separate protocol engine through a one-cycle start pulse. It holds the busy flag until the engine reports done. It then records the outcome in a status register that software clears by writing ones.

A buffer of `BUF_DEPTH` bytes backs block transfers. Software fills or drains it one byte per access through the block-data port. Any read of the control register rewinds the port's pointer to the first byte. The engine reaches the same buffer through its own index, write and read signals. Read transactions return their data bytes from the engine into the two data registers. The engine also writes the byte count of a block read into the first data register.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register offset reads 0x00, `irq` is low, `eng_start` is low and every buffer byte is 0x00.
- R2: Offsets: 0 host status, 1 slave status (always reads 0x00), 2 control, 3 command, 4 target address, 5 data0, 6 data1, 7 block-data port. Command, address, data0 and data1 read back the last value written. Control keeps bits 4:2 (protocol) and bit 0 (interrupt enable). All other control bits read as zero, including start bit 6.
- R3: A control write with bit 6 set, while idle and with a valid request, starts a transaction. `eng_start` is high for exactly the following cycle, and status bit 0 (busy) reads 1 from then on. `eng_proto`, `eng_target`, `eng_cmd`, `eng_wdat0` and `eng_wdat1` show the control bits 4:2 and the address, command, data0 and data1 registers.
- R4: While busy, a start request produces no `eng_start` pulse. Writes to control, command, address, data0 and data1 are ignored.
- R5: `eng_done` while busy clears busy on the next cycle. If `eng_err` is zero, status bit 1 (done) sets. Otherwise `eng_err` bits 0, 1 and 2 set status bits 2 (no response), 3 (collision) and 4 (failed), and the done bit is not set. `eng_done` while idle changes nothing.
- R6: When a transaction whose address bit 0 is 1 (read) completes without error, data0 and data1 take `eng_rdat0` and `eng_rdat1`. In all other cases they keep their values.
- R7: A write to status clears each of bits 4:1 where the written byte has a one. Bit 0 cannot be changed by software. Writing back the value just read while idle leaves the status at 0x00.
- R8: A start is rejected in either of two cases. The first is a protocol code other than 000 (quick), 001 (byte), 010 (byte data), 011 (word) or 101 (block). The second is a block write (code 101, address bit 0 = 0) whose data0 count is 0 or above `BUF_DEPTH`. A rejected start gives no `eng_start`, leaves busy at 0 and sets status bit 4 on the next cycle.
- R9: Each write to the block port stores the byte at the pointer and advances the pointer. Each read returns the byte at the pointer and advances it. From the last byte the pointer wraps to the first.
- R10: Any read of the control register returns the pointer to byte 0.
- R11: `eng_buf_rdata` shows the buffer byte at `eng_buf_idx`. `eng_buf_we` writes `eng_buf_wdata` there. When the engine and the block port write the same byte in one cycle, the engine's value is kept.
- R12: `irq` is high exactly when control bit 0 is set and any of status bits 4:1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle transaction launch |
| eng_proto | output | 3 | Protocol code |
| eng_target | output | 8 | Target address byte, bit 0 = read |
| eng_cmd | output | 8 | Command byte |
| eng_wdat0 | output | 8 | Data0 register |
| eng_wdat1 | output | 8 | Data1 register |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 3 | Completion errors: bit 2 failed, bit 1 collision, bit 0 no response |
| eng_rdat0 | input | 8 | Returned data0 / block count |
| eng_rdat1 | input | 8 | Returned data1 |
| eng_buf_idx | input | $clog2(BUF_DEPTH) | Engine buffer index |
| eng_buf_we | input | 1 | Engine buffer write |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Buffer byte at `eng_buf_idx` |

## Verification
The assertions watch a set of rules on every cycle:
- a launch never appears without busy, and a start while busy never launches;
- a completion drops busy and records either done or the reported error bits;
- a rejected request leaves busy low with the failed flag set;
- a one written to a flag clears it;
- the block pointer rewinds and wraps.

Several behaviours need the bench's scenarios, because they depend on data values and the order of accesses:
- data returned only on error-free reads;
- register contents frozen during a transaction;
- the byte count limits of block writes;
- the buffer's byte ordering through the port;
- the engine winning a same-byte write.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;

    localparam int BYTE_W = 8;

    // register offsets
    localparam logic [2:0] OFS_HSTS = 3'd0;
    localparam logic [2:0] OFS_SSTS = 3'd1;
    localparam logic [2:0] OFS_CTRL = 3'd2;
    localparam logic [2:0] OFS_CMD  = 3'd3;
    localparam logic [2:0] OFS_ADDR = 3'd4;
    localparam logic [2:0] OFS_DAT0 = 3'd5;
    localparam logic [2:0] OFS_DAT1 = 3'd6;
    localparam logic [2:0] OFS_BLK  = 3'd7;

    // status bit positions
    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 1;
    localparam int ST_NACK = 2;
    localparam int ST_COLL = 3;
    localparam int ST_FAIL = 4;

    // control bit positions
    localparam int CT_IEN   = 0;
    localparam int CT_PLO   = 2;
    localparam int CT_PHI   = 4;
    localparam int CT_START = 6;

    // protocol codes
    localparam logic [2:0] PR_QUICK = 3'd0;
    localparam logic [2:0] PR_BYTE  = 3'd1;
    localparam logic [2:0] PR_BDATA = 3'd2;
    localparam logic [2:0] PR_WORD  = 3'd3;
    localparam logic [2:0] PR_BLOCK = 3'd5;

    typedef struct packed {
        logic fail;
        logic coll;
        logic nack;
    } err_t;

    typedef struct packed {
        logic [2:0]        proto;
        logic [BYTE_W-1:0] target;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] dat0;
        logic [BYTE_W-1:0] dat1;
    } xfer_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_cmd;
        logic wr_addr;
        logic wr_dat0;
        logic wr_dat1;
        logic wr_sts;
        logic wr_blk;
        logic rd_ctrl;
        logic rd_blk;
    } strobe_t;

    function automatic logic proto_known(input logic [2:0] p);
        return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
               (p == PR_WORD)  || (p == PR_BLOCK);
    endfunction

    function automatic logic launch_ok(input logic [2:0] p, input logic is_read,
                                       input logic [BYTE_W-1:0] cnt, input int depth);
        if (!proto_known(p))
            return 1'b0;
        if ((p == PR_BLOCK) && !is_read && ((cnt == '0) || (int'(cnt) > depth)))
            return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/smb_ctrl_seq.sv
module smb_ctrl_seq
    import smb_regs_pkg::*;
#(
    parameter int BUF_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           stb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              busy,
    input  logic              eng_done,
    input  err_t              eng_err,
    input  logic [BYTE_W-1:0] rdat0,
    input  logic [BYTE_W-1:0] rdat1,
    output xfer_t             xfer,
    output logic              ien,
    output logic              launch,
    output logic              reject,
    output logic              start_q
);

    logic start_req;
    logic req_ok;
    logic finish_rd;

    assign start_req = stb.wr_ctrl && wdata[CT_START] && !busy;
    assign req_ok    = launch_ok(wdata[CT_PHI:CT_PLO], xfer.target[0], xfer.dat0, BUF_DEPTH);
    assign launch    = start_req && req_ok;
    assign reject    = start_req && !req_ok;
    assign finish_rd = busy && eng_done && (eng_err == '0) && xfer.target[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer    <= '0;
            ien     <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= launch;
            if (!busy) begin
                if (stb.wr_ctrl) begin
                    xfer.proto <= wdata[CT_PHI:CT_PLO];
                    ien        <= wdata[CT_IEN];
                end
                if (stb.wr_cmd)  xfer.cmd    <= wdata;
                if (stb.wr_addr) xfer.target <= wdata;
                if (stb.wr_dat0) xfer.dat0   <= wdata;
                if (stb.wr_dat1) xfer.dat1   <= wdata;
            end
            if (finish_rd) begin
                xfer.dat0 <= rdat0;
                xfer.dat1 <= rdat1;
            end
        end
    end

    // R3: a launch pulse only ever appears with busy already recorded
    a_r3_start_with_busy: assert property (@(posedge clk) disable iff (rst)
        start_q |-> busy);

    // R4: start request during a transaction never launches
    a_r4_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && stb.wr_ctrl) |=> !start_q);

    // R4, R6: transfer registers frozen while the engine is working
    a_r4_frozen_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !eng_done) |=> $stable(xfer));

endmodule

// File: rtl/smb_status_reg.sv
module smb_status_reg
    import smb_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch,
    input  logic                 reject,
    input  logic                 eng_done,
    input  err_t                 eng_err,
    input  logic                 w1c,
    input  logic [ST_FAIL:ST_DONE] w1c_mask,
    output logic [BYTE_W-1:0]    status,
    output logic                 busy
);

    logic                   busy_q;
    logic [ST_FAIL:ST_DONE] flags_q;
    logic [ST_FAIL:ST_DONE] flags_n;
    logic                   finish;

    assign finish = busy_q && eng_done;
    assign busy   = busy_q;
    assign status = {3'b000, flags_q, busy_q};

    always_comb begin
        flags_n = flags_q;
        if (w1c)
            flags_n = flags_n & ~w1c_mask;
        if (finish) begin
            if (eng_err == '0) begin
                flags_n[ST_DONE] = 1'b1;
            end else begin
                flags_n[ST_NACK] = flags_n[ST_NACK] | eng_err.nack;
                flags_n[ST_COLL] = flags_n[ST_COLL] | eng_err.coll;
                flags_n[ST_FAIL] = flags_n[ST_FAIL] | eng_err.fail;
            end
        end
        if (reject)
            flags_n[ST_FAIL] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            flags_q <= '0;
        end else begin
            flags_q <= flags_n;
            if (launch)
                busy_q <= 1'b1;
            else if (finish)
                busy_q <= 1'b0;
        end
    end

    // R5: completion releases busy
    a_r5_busy_drops: assert property (@(posedge clk) disable iff (rst)
        finish |=> !status[ST_BUSY]);

    // R5: clean completion reports done
    a_r5_done_flag: assert property (@(posedge clk) disable iff (rst)
        (finish && eng_err == '0) |=> status[ST_DONE]);

    // R5: faulty completion reports each error bit given
    a_r5_err_flags: assert property (@(posedge clk) disable iff (rst)
        (finish && eng_err != '0) |=>
            ((status[ST_FAIL:ST_NACK] & $past(eng_err)) == $past(eng_err)));

    // R7: a one written to the done flag clears it unless a completion lands
    a_r7_w1c_done: assert property (@(posedge clk) disable iff (rst)
        (w1c && w1c_mask[ST_DONE] && !finish) |=> !status[ST_DONE]);

    // R8: rejected request never becomes busy and flags failure
    a_r8_reject: assert property (@(posedge clk) disable iff (rst)
        (reject && !busy_q) |=> (!status[ST_BUSY] && status[ST_FAIL]));

endmodule

// File: rtl/smb_blk_buf.sv
module smb_blk_buf
    import smb_regs_pkg::*;
#(
    parameter  int BUF_DEPTH = 32,
    localparam int PW        = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic              rewind,
    input  logic [BYTE_W-1:0] port_wdata,
    output logic [BYTE_W-1:0] port_rdata,
    input  logic [PW-1:0]     eng_idx,
    input  logic              eng_we,
    input  logic [BYTE_W-1:0] eng_wdata,
    output logic [BYTE_W-1:0] eng_rdata
);

    localparam logic [PW-1:0] LAST = PW'(BUF_DEPTH - 1);

    logic [BYTE_W-1:0] mem [BUF_DEPTH];
    logic [PW-1:0]     ptr;
    logic              step;
    logic              port_blocked;

    assign step         = port_wr || port_rd;
    assign port_blocked = eng_we && (eng_idx == ptr);
    assign port_rdata   = mem[ptr];
    assign eng_rdata    = mem[eng_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (rewind) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BUF_DEPTH; i++)
                mem[i] <= '0;
        end else begin
            if (eng_we)
                mem[eng_idx] <= eng_wdata;
            if (port_wr && !port_blocked)
                mem[ptr] <= port_wdata;
        end
    end

    // R10: control read returns the pointer to byte 0
    a_r10_rewind: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (ptr == '0));

    // R9: pointer wraps after the last byte
    a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !rewind && ptr == LAST) |=> (ptr == '0));

    // R9: no access, no movement
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !rewind) |=> $stable(ptr));

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_regs_pkg::*;
#(
    parameter int BUF_DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [2:0]                   reg_addr,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [7:0]                   reg_wdata,
    output logic [7:0]                   reg_rdata,
    output logic                         irq,
    output logic                         eng_start,
    output logic [2:0]                   eng_proto,
    output logic [7:0]                   eng_target,
    output logic [7:0]                   eng_cmd,
    output logic [7:0]                   eng_wdat0,
    output logic [7:0]                   eng_wdat1,
    input  logic                         eng_done,
    input  logic [2:0]                   eng_err,
    input  logic [7:0]                   eng_rdat0,
    input  logic [7:0]                   eng_rdat1,
    input  logic [$clog2(BUF_DEPTH)-1:0] eng_buf_idx,
    input  logic                         eng_buf_we,
    input  logic [7:0]                   eng_buf_wdata,
    output logic [7:0]                   eng_buf_rdata
);

    strobe_t           stb;
    xfer_t             xfer;
    err_t              err_in;
    logic              ien;
    logic              launch;
    logic              reject;
    logic              busy;
    logic [BYTE_W-1:0] status;
    logic [BYTE_W-1:0] blk_rdata;
    logic [BYTE_W-1:0] ctrl_view;

    assign err_in = err_t'(eng_err);

    always_comb begin
        stb         = '0;
        stb.wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
        stb.wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
        stb.wr_addr = reg_wr && (reg_addr == OFS_ADDR);
        stb.wr_dat0 = reg_wr && (reg_addr == OFS_DAT0);
        stb.wr_dat1 = reg_wr && (reg_addr == OFS_DAT1);
        stb.wr_sts  = reg_wr && (reg_addr == OFS_HSTS);
        stb.wr_blk  = reg_wr && (reg_addr == OFS_BLK);
        stb.rd_ctrl = reg_rd && (reg_addr == OFS_CTRL);
        stb.rd_blk  = reg_rd && (reg_addr == OFS_BLK);
    end

    smb_ctrl_seq #(.BUF_DEPTH(BUF_DEPTH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .stb      (stb),
        .wdata    (reg_wdata),
        .busy     (busy),
        .eng_done (eng_done),
        .eng_err  (err_in),
        .rdat0    (eng_rdat0),
        .rdat1    (eng_rdat1),
        .xfer     (xfer),
        .ien      (ien),
        .launch   (launch),
        .reject   (reject),
        .start_q  (eng_start)
    );

    smb_status_reg u_sts (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .reject   (reject),
        .eng_done (eng_done),
        .eng_err  (err_in),
        .w1c      (stb.wr_sts),
        .w1c_mask (reg_wdata[ST_FAIL:ST_DONE]),
        .status   (status),
        .busy     (busy)
    );

    smb_blk_buf #(.BUF_DEPTH(BUF_DEPTH)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .port_wr    (stb.wr_blk),
        .port_rd    (stb.rd_blk),
        .rewind     (stb.rd_ctrl),
        .port_wdata (reg_wdata),
        .port_rdata (blk_rdata),
        .eng_idx    (eng_buf_idx),
        .eng_we     (eng_buf_we),
        .eng_wdata  (eng_buf_wdata),
        .eng_rdata  (eng_buf_rdata)
    );

    always_comb begin
        ctrl_view                 = '0;
        ctrl_view[CT_PHI:CT_PLO]  = xfer.proto;
        ctrl_view[CT_IEN]         = ien;
    end

    always_comb begin
        case (reg_addr)
            OFS_HSTS: reg_rdata = status;
            OFS_CTRL: reg_rdata = ctrl_view;
            OFS_CMD:  reg_rdata = xfer.cmd;
            OFS_ADDR: reg_rdata = xfer.target;
            OFS_DAT0: reg_rdata = xfer.dat0;
            OFS_DAT1: reg_rdata = xfer.dat1;
            OFS_BLK:  reg_rdata = blk_rdata;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq        = ien && (status[ST_FAIL:ST_DONE] != '0);
    assign eng_proto  = xfer.proto;
    assign eng_target = xfer.target;
    assign eng_cmd    = xfer.cmd;
    assign eng_wdat0  = xfer.dat0;
    assign eng_wdat1  = xfer.dat1;

    // R3: launch and rejection never coincide with a busy transaction
    a_r3_launch_idle: assert property (@(posedge clk) disable iff (rst)
        (launch || reject) |-> !status[ST_BUSY]);

endmodule

// File: tb/smb_host_regs_test.sv
`timescale 1ns/1ps
module smb_host_regs_test;

    localparam int DEPTH = 32;
    localparam int PW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          irq;
    logic          eng_start;
    logic [2:0]    eng_proto;
    logic [7:0]    eng_target, eng_cmd, eng_wdat0, eng_wdat1;
    logic          eng_done = 1'b0;
    logic [2:0]    eng_err = '0;
    logic [7:0]    eng_rdat0 = '0, eng_rdat1 = '0;
    logic [PW-1:0] eng_buf_idx = '0;
    logic          eng_buf_we = 1'b0;
    logic [7:0]    eng_buf_wdata = '0;
    logic [7:0]    eng_buf_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int start_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    smb_host_regs #(.BUF_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .eng_start(eng_start),
        .eng_proto(eng_proto), .eng_target(eng_target), .eng_cmd(eng_cmd),
        .eng_wdat0(eng_wdat0), .eng_wdat1(eng_wdat1), .eng_done(eng_done),
        .eng_err(eng_err), .eng_rdat0(eng_rdat0), .eng_rdat1(eng_rdat1),
        .eng_buf_idx(eng_buf_idx), .eng_buf_we(eng_buf_we),
        .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata)
    );

    always @(negedge clk) if (eng_start) start_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic finish_eng(input logic [2:0] e, input logic [7:0] r0, input logic [7:0] r1);
        @(negedge clk);
        eng_done = 1'b1; eng_err = e; eng_rdat0 = r0; eng_rdat1 = r1;
        @(negedge clk);
        eng_done = 1'b0; eng_err = '0;
    endtask

    function automatic logic [7:0] ctrl_word(input logic go, input logic [2:0] p, input logic ie);
        return {1'b0, go, 1'b0, p, 1'b0, ie};
    endfunction

    function automatic logic [7:0] exp_status(input logic [2:0] e);
        return (e == 3'b000) ? 8'h02 : {3'b000, e, 2'b00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset reg", v, 8'h00);
        end
        check("R1 irq", irq, 1'b0);
        check("R1 eng_start", eng_start, 1'b0);
        check("R1 buffer", eng_buf_rdata, 8'h00);

        // R2: readback
        wr(3'd3, 8'h5A); rd(3'd3, v); check("R2 cmd", v, 8'h5A);
        wr(3'd4, 8'hC3); rd(3'd4, v); check("R2 addr", v, 8'hC3);
        wr(3'd5, 8'h11); rd(3'd5, v); check("R2 dat0", v, 8'h11);
        wr(3'd6, 8'hEE); rd(3'd6, v); check("R2 dat1", v, 8'hEE);
        wr(3'd2, 8'h95); rd(3'd2, v); check("R2 ctrl mask", v, 8'h15);
        wr(3'd1, 8'hFF); rd(3'd1, v); check("R2 slave status", v, 8'h00);
        check("R2 no launch", start_cnt, 0);
        wr(3'd2, 8'h00);

        // R5: done while idle
        finish_eng(3'b111, 8'h00, 8'h00);
        rd(3'd0, v); check("R5 idle done ignored", v, 8'h00);

        // R8: unknown protocol
        wr(3'd2, ctrl_word(1'b1, 3'd4, 1'b0));
        check("R8 no start code4", eng_start, 1'b0);
        rd(3'd0, v); check("R8 fail flag", v, 8'h10);
        wr(3'd0, v); rd(3'd0, v); check("R7 writeback clears", v, 8'h00);

        // R8: block write count limits
        wr(3'd4, 8'hA0);
        wr(3'd5, 8'd0);
        wr(3'd2, ctrl_word(1'b1, 3'd5, 1'b0));
        rd(3'd0, v); check("R8 count zero", v, 8'h10);
        wr(3'd0, 8'hFF);
        wr(3'd5, 8'(DEPTH + 1));
        wr(3'd2, ctrl_word(1'b1, 3'd5, 1'b0));
        rd(3'd0, v); check("R8 count over", v, 8'h10);
        wr(3'd0, 8'hFF);
        check("R8 no launches", start_cnt, 0);
        wr(3'd5, 8'(DEPTH));
        wr(3'd2, ctrl_word(1'b1, 3'd5, 1'b0));
        check("R8 count max launches", eng_start, 1'b1);
        // R7: busy cannot be cleared by software
        wr(3'd0, 8'h01);
        rd(3'd0, v); check("R7 busy kept", v, 8'h01);
        finish_eng(3'b101, 8'h00, 8'h00);
        rd(3'd0, v); check("R5 err bits", v, 8'h14);
        wr(3'd0, 8'h04); rd(3'd0, v); check("R7 partial clear", v, 8'h10);
        wr(3'd0, 8'h10); rd(3'd0, v); check("R7 cleared", v, 8'h00);

        // R9, R10: block port fill and drain with wrap
        rd(3'd2, v);
        for (int i = 0; i < DEPTH; i++) wr(3'd7, 8'(8'h40 + i));
        rd(3'd2, v);
        for (int i = 0; i < DEPTH; i++) begin
            rd(3'd7, v);
            check("R9 port byte", v, 8'(8'h40 + i));
        end
        rd(3'd7, v); check("R9 wrap", v, 8'h40);
        rd(3'd7, v); check("R9 after wrap", v, 8'h41);
        rd(3'd2, v); rd(3'd7, v); check("R10 rewind", v, 8'h40);

        // R11: engine side view and priority
        @(negedge clk); eng_buf_idx = PW'(7);
        #1 check("R11 engine read", eng_buf_rdata, 8'h47);
        @(negedge clk);
        eng_buf_idx = PW'(3); eng_buf_wdata = 8'hA5; eng_buf_we = 1'b1;
        @(negedge clk); eng_buf_we = 1'b0;
        rd(3'd2, v);
        @(negedge clk);
        eng_buf_idx = '0; eng_buf_wdata = 8'h3C; eng_buf_we = 1'b1;
        reg_addr = 3'd7; reg_wdata = 8'hC3; reg_wr = 1'b1;
        @(negedge clk); eng_buf_we = 1'b0; reg_wr = 1'b0;
        rd(3'd2, v);
        rd(3'd7, v); check("R11 engine wins", v, 8'h3C);
        rd(3'd7, v); check("R9 next byte", v, 8'h41);
        rd(3'd7, v); check("R9 next byte", v, 8'h42);
        rd(3'd7, v); check("R11 engine write", v, 8'hA5);

        // R6: block read returns count, bytes land in buffer
        wr(3'd4, 8'hA1);
        wr(3'd2, ctrl_word(1'b1, 3'd5, 1'b1));
        check("R3 block read start", eng_start, 1'b1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            eng_buf_idx = PW'(i); eng_buf_wdata = 8'(8'h90 + i); eng_buf_we = 1'b1;
        end
        @(negedge clk); eng_buf_we = 1'b0;
        finish_eng(3'b000, 8'd5, 8'h00);
        check("R12 irq on done", irq, 1'b1);
        rd(3'd5, v); check("R6 block count", v, 8'd5);
        rd(3'd2, v);
        for (int i = 0; i < 5; i++) begin
            rd(3'd7, v); check("R6 block byte", v, 8'(8'h90 + i));
        end
        wr(3'd0, 8'h02);
        check("R12 irq cleared", irq, 1'b0);

        // random transactions
        for (int n = 0; n < 60; n++) begin
            logic [2:0] p, e;
            logic [7:0] t, c, d0, d1, r0, r1;
            logic ie;
            int sc;
            p  = 3'($urandom_range(0, 3));
            t  = 8'($urandom); c = 8'($urandom);
            d0 = 8'($urandom); d1 = 8'($urandom);
            r0 = 8'($urandom); r1 = 8'($urandom);
            ie = 1'($urandom);
            e  = ($urandom_range(0, 1) == 1) ? 3'($urandom_range(1, 7)) : 3'b000;
            wr(3'd4, t); wr(3'd3, c); wr(3'd5, d0); wr(3'd6, d1);
            sc = start_cnt;
            wr(3'd2, ctrl_word(1'b1, p, ie));
            check("R3 start pulse", eng_start, 1'b1);
            check("R3 proto", eng_proto, p);
            check("R3 target", eng_target, t);
            check("R3 cmd", eng_cmd, c);
            check("R3 wdat", {eng_wdat0, eng_wdat1}, {d0, d1});
            rd(3'd0, v); check("R3 busy", v, 8'h01);
            wr(3'd3, ~c);
            wr(3'd2, ctrl_word(1'b1, 3'd1 ^ p, ~ie));
            check("R4 start ignored", start_cnt, sc + 1);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            finish_eng(e, r0, r1);
            rd(3'd0, v); check("R5 outcome", v, exp_status(e));
            check("R12 irq", irq, ie);
            rd(3'd5, v); check("R6 dat0", v, (t[0] && e == 3'b000) ? r0 : d0);
            rd(3'd6, v); check("R6 dat1", v, (t[0] && e == 3'b000) ? r1 : d1);
            rd(3'd3, v); check("R4 cmd frozen", v, c);
            rd(3'd2, v); check("R4 ctrl frozen", v, ctrl_word(1'b0, p, ie));
            rd(3'd0, v); wr(3'd0, v);
            rd(3'd0, v); check("R7 writeback zero", v, 8'h00);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule